// File: doc/BRIEF.md
# Pass-Through Add-On Access Port

This block sits on the add-on side of a bus-bridge pass-through channel. A host-side stub posts one transfer at a time: a 32-bit target address, a direction bit and, for host writes, a 32-bit data word. The block latches the transfer and raises a pending flag together with a direction flag. The add-on logic uses the same clock and finds the target address in one of two ways. It can assert a dedicated active-low address strobe, which places the address on the add-on data bus at once. It can also issue an ordinary register read of the address register.

The add-on moves the payload through a 32-bit data register. It may use one 32-bit access or several narrow accesses, in any number. When it is finished it pulls the active-low ready input low. The transfer stays open until that happens, so the add-on can stretch it for as long as it needs. On the ready edge the block closes the transfer. It sends the host side a one-cycle completion pulse together with a snapshot of the data register, which carries the result of a host read. A static width pin selects a 32-bit or a 16-bit add-on data bus.

Top module: `ptap_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pending`, `is_write`, `done` and `dout_oe` are all 0.
- R2: When `post_valid` is 1 and no transfer is pending, the next clock edge sets `pending` to 1, sets `is_write` to `post_write` and captures `post_addr`. A post that arrives while a transfer is pending changes neither the address nor the direction.
- R3: While `pending` is 1 and `ready_n` is 1, the transfer stays pending. On the edge where `ready_n` is sampled 0 during a pending transfer, `pending` and `is_write` fall to 0. On that same edge `done` is high for exactly one cycle and `done_rdata` takes the value the data register held.
- R4: A `ready_n` assertion while no transfer is pending has no effect, and it never produces a `done` pulse.
- R5: While `adr_strobe_n` is 0 in 32-bit mode (`wide_mode`=1), `dout_oe` is 1 and `dout` equals the captured address in the same cycle. This holds for any `reg_adr`, `be_n` and `sel_n`.
- R6: While `adr_strobe_n` is 0 in 16-bit mode (`wide_mode`=0), `dout[15:0]` is the low half of the captured address and `dout[31:16]` is 0, whatever `be_n` is.
- R7: A register read (`sel_n`=0, `rd_n`=0, strobe inactive) drives `dout_oe`=1. In 32-bit mode `dout` is the address register at `reg_adr`=10 (byte offset 0x28), the data register at `reg_adr`=8 (byte offset 0x20), and 0 at any other index.
- R8: In 32-bit mode, a register write (`sel_n`=0, `wr_n`=0) to `reg_adr`=8 during a pending transfer updates byte lane i (bits 8i+7..8i) from `din` wherever `be_n[i]`=0. All other lanes keep their value.
- R9: In 16-bit mode, the halves of the 32-bit register are chosen as follows. If either of `be_n[1:0]` is 0, the lower half (bits 15..0) is selected. Otherwise, if either of `be_n[3:2]` is 0, the upper half (bits 31..16) is selected. Reads return the selected half on `dout[15:0]` with `dout[31:16]`=0, and a read with no byte enable active returns the lower half. Writes store `din[15:0]` into the selected half, and a write with no byte enable active stores nothing.
- R10: `dout_oe` is 0 whenever `adr_strobe_n` is 1 and no register read (`sel_n`=0 and `rd_n`=0) is in progress.
- R11: A data-register write has no effect if no transfer is pending, or if `adr_strobe_n` is 0 during the write.
- R12: Accepting a post loads the data register with `post_wdata` when `post_write` is 1, and with 0 when `post_write` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state and status change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | Static bus width: 1 = 32-bit add-on bus, 0 = 16-bit |
| post_valid | input | 1 | Host stub posts a transfer this cycle |
| post_write | input | 1 | Direction of the posted transfer: 1 = host write |
| post_addr | input | 32 | Target address of the posted transfer |
| post_wdata | input | 32 | Host write data for the posted transfer |
| done | output | 1 | One-cycle completion pulse to the host stub |
| done_rdata | output | 32 | Data register snapshot taken at completion |
| pending | output | 1 | A transfer is open on the add-on side |
| is_write | output | 1 | Direction of the open transfer: 1 = host write |
| sel_n | input | 1 | Active-low register select |
| rd_n | input | 1 | Active-low register read strobe |
| wr_n | input | 1 | Active-low register write strobe |
| reg_adr | input | 5 | Register word index (byte offset bits 6..2) |
| be_n | input | 4 | Active-low byte enables |
| adr_strobe_n | input | 1 | Active-low direct read of the captured address |
| din | input | 32 | Add-on write data |
| dout | output | 32 | Add-on read data |
| dout_oe | output | 1 | Add-on data bus output enable |
| ready_n | input | 1 | Active-low add-on completion |

## Verification
The hardest case to reach is the 16-bit half selection. A partial byte-enable code must first fall back on its half-priority rule, and the result only shows up when the register is read back through the narrow port. The stimulus keeps one transfer open for the whole sweep. It writes through all sixteen byte-enable codes and reads back both halves after each write. The data stays live because ready is held off for hundreds of cycles. The strobe is swept in the same way across every index, byte-enable and select combination. This shows that the inputs it must ignore really have no effect.

// File: rtl/ptap_pkg.sv
package ptap_pkg;

  // Kind of add-on access decoded in the current cycle.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_READ   = 2'd1,
    ACC_WRITE  = 2'd2,
    ACC_STROBE = 2'd3
  } acc_kind_e;

  // Narrow-bus half choice: the upper half is used only when some upper
  // lane is enabled and no lower lane is.
  function automatic logic pick_upper(input logic lo_any, input logic hi_any);
    return hi_any & ~lo_any;
  endfunction

endpackage

// File: rtl/ptap_decode.sv
module ptap_decode
  import ptap_pkg::*;
#(
  parameter int ADR_W      = 5,
  parameter int BE_W       = 4,
  parameter int STROBE_IDX = 10
) (
  input  logic             sel_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             strobe_n,
  input  logic [ADR_W-1:0] reg_adr,
  input  logic [BE_W-1:0]  be_n,
  output acc_kind_e        kind,
  output logic [ADR_W-1:0] idx,
  output logic [BE_W-1:0]  be
);

  localparam logic [ADR_W-1:0] STROBE_IDX_V = ADR_W'(STROBE_IDX);

  always_comb begin
    kind = ACC_NONE;
    idx  = reg_adr;
    be   = ~be_n;
    if (!strobe_n) begin
      // Direct address access: fixed index, every lane enabled.
      kind = ACC_STROBE;
      idx  = STROBE_IDX_V;
      be   = '1;
    end else if (!sel_n && !rd_n) begin
      kind = ACC_READ;
    end else if (!sel_n && !wr_n) begin
      kind = ACC_WRITE;
    end
  end

endmodule

// File: rtl/ptap_status.sv
module ptap_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_valid,
  input  logic              post_write,
  input  logic [DATA_W-1:0] post_addr,
  input  logic              ready_n,
  input  logic [DATA_W-1:0] data_q,
  output logic              accept,
  output logic              pending,
  output logic              is_write,
  output logic [DATA_W-1:0] addr_q,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata
);

  logic complete;

  assign accept   = post_valid & ~pending;
  assign complete = pending & ~ready_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      is_write   <= 1'b0;
      addr_q     <= '0;
      done       <= 1'b0;
      done_rdata <= '0;
    end else begin
      done <= complete;
      if (complete) begin
        pending    <= 1'b0;
        is_write   <= 1'b0;
        done_rdata <= data_q;
      end else if (accept) begin
        pending  <= 1'b1;
        is_write <= post_write;
        addr_q   <= post_addr;
      end
    end
  end

endmodule

// File: rtl/ptap_datareg.sv
module ptap_datareg
  import ptap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_write,
  input  logic [DATA_W-1:0] load_data,
  input  logic              wr_en,
  input  logic              wide_mode,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data_q
);

  localparam int BE_W       = DATA_W / 8;
  localparam int HALF_LANES = BE_W / 2;

  logic lo_any;
  logic hi_any;
  logic up_sel;

  assign lo_any = |be[HALF_LANES-1:0];
  assign hi_any = |be[BE_W-1:HALF_LANES];
  assign up_sel = pick_upper(lo_any, hi_any);

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic       lane_we;
    logic [7:0] lane_val;
    logic [7:0] q;

    if (g < HALF_LANES) begin : g_low
      always_comb begin
        lane_val = din[8*g +: 8];
        lane_we  = wide_mode ? be[g] : lo_any;
      end
    end else begin : g_high
      always_comb begin
        lane_val = wide_mode ? din[8*g +: 8] : din[8*(g-HALF_LANES) +: 8];
        lane_we  = wide_mode ? be[g] : up_sel;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= 8'h00;
      end else if (load) begin
        q <= load_write ? load_data[8*g +: 8] : 8'h00;
      end else if (wr_en && lane_we) begin
        q <= lane_val;
      end
    end

    assign data_q[8*g +: 8] = q;
  end

endmodule

// File: rtl/ptap_readmux.sv
module ptap_readmux
  import ptap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADR_W    = 5,
  parameter int ADDR_IDX = 10,
  parameter int DATA_IDX = 8
) (
  input  acc_kind_e           kind,
  input  logic [ADR_W-1:0]    idx,
  input  logic [DATA_W/8-1:0] be,
  input  logic                wide_mode,
  input  logic [DATA_W-1:0]   addr_q,
  input  logic [DATA_W-1:0]   data_q,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_oe
);

  localparam int BE_W       = DATA_W / 8;
  localparam int HALF_LANES = BE_W / 2;
  localparam int HALF_W     = DATA_W / 2;

  logic [DATA_W-1:0] word;
  logic              up_sel;

  assign up_sel  = pick_upper(|be[HALF_LANES-1:0], |be[BE_W-1:HALF_LANES]);
  assign dout_oe = (kind == ACC_READ) || (kind == ACC_STROBE);

  always_comb begin
    if (idx == ADR_W'(ADDR_IDX))      word = addr_q;
    else if (idx == ADR_W'(DATA_IDX)) word = data_q;
    else                              word = '0;
  end

  always_comb begin
    dout = '0;
    if (dout_oe) begin
      if (wide_mode)   dout = word;
      else if (up_sel) dout = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
      else             dout = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
    end
  end

endmodule

// File: rtl/ptap_port.sv
module ptap_port
  import ptap_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int ADR_W           = 5,
  parameter int ADDR_REG_OFFSET = 'h28,
  parameter int DATA_REG_OFFSET = 'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic                post_valid,
  input  logic                post_write,
  input  logic [DATA_W-1:0]   post_addr,
  input  logic [DATA_W-1:0]   post_wdata,
  output logic                done,
  output logic [DATA_W-1:0]   done_rdata,
  output logic                pending,
  output logic                is_write,
  input  logic                sel_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [ADR_W-1:0]    reg_adr,
  input  logic [DATA_W/8-1:0] be_n,
  input  logic                adr_strobe_n,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_oe,
  input  logic                ready_n
);

  localparam int BE_W     = DATA_W / 8;
  localparam int ADDR_IDX = ADDR_REG_OFFSET / 4;
  localparam int DATA_IDX = DATA_REG_OFFSET / 4;

  acc_kind_e         kind;
  logic [ADR_W-1:0]  idx;
  logic [BE_W-1:0]   be;
  logic              accept;
  logic              wr_en;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  ptap_decode #(
    .ADR_W(ADR_W), .BE_W(BE_W), .STROBE_IDX(ADDR_IDX)
  ) u_decode (
    .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .strobe_n(adr_strobe_n),
    .reg_adr(reg_adr), .be_n(be_n), .kind(kind), .idx(idx), .be(be)
  );

  ptap_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_write(post_write),
    .post_addr(post_addr), .ready_n(ready_n), .data_q(data_q),
    .accept(accept), .pending(pending), .is_write(is_write),
    .addr_q(addr_q), .done(done), .done_rdata(done_rdata)
  );

  assign wr_en = (kind == ACC_WRITE) && (idx == ADR_W'(DATA_IDX)) && pending;

  ptap_datareg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .load(accept), .load_write(post_write),
    .load_data(post_wdata), .wr_en(wr_en), .wide_mode(wide_mode),
    .be(be), .din(din), .data_q(data_q)
  );

  ptap_readmux #(
    .DATA_W(DATA_W), .ADR_W(ADR_W), .ADDR_IDX(ADDR_IDX), .DATA_IDX(DATA_IDX)
  ) u_rmux (
    .kind(kind), .idx(idx), .be(be), .wide_mode(wide_mode),
    .addr_q(addr_q), .data_q(data_q), .dout(dout), .dout_oe(dout_oe)
  );

endmodule

// File: rtl/ptap_checker.sv
module ptap_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic              post_valid,
  input logic              post_write,
  input logic              pending,
  input logic              is_write,
  input logic              done,
  input logic              sel_n,
  input logic              rd_n,
  input logic              adr_strobe_n,
  input logic              ready_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic [DATA_W-1:0] addr_q
);

  localparam int HALF_W = DATA_W / 2;

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    (adr_strobe_n && (sel_n || rd_n)) |-> !dout_oe); // R10
  AST_STROBE_FULL: assert property (@(posedge clk) disable iff (rst)
    (!adr_strobe_n && wide_mode) |-> (dout_oe && dout == addr_q)); // R5
  AST_STROBE_HALF: assert property (@(posedge clk) disable iff (rst)
    (!adr_strobe_n && !wide_mode) |->
      (dout_oe && dout == {{HALF_W{1'b0}}, addr_q[HALF_W-1:0]})); // R6
  AST_POST_OPENS: assert property (@(posedge clk) disable iff (rst)
    (post_valid && !pending) |=> (pending && is_write == $past(post_write))); // R2
  AST_POST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (pending && ready_n) |=> (pending && $stable(addr_q) && $stable(is_write))); // R2
  AST_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    (pending && !ready_n) |=> (!pending && !is_write && done)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    (!pending && !ready_n) |=> !done); // R4

endmodule

bind ptap_port ptap_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .post_valid(post_valid),
  .post_write(post_write), .pending(pending), .is_write(is_write),
  .done(done), .sel_n(sel_n), .rd_n(rd_n), .adr_strobe_n(adr_strobe_n),
  .ready_n(ready_n), .dout(dout), .dout_oe(dout_oe), .addr_q(addr_q)
);

// File: tb/sim_ptap_port.sv
module sim_ptap_port;

  logic        clk = 1'b0;
  logic        rst;
  logic        wide_mode;
  logic        post_valid, post_write;
  logic [31:0] post_addr, post_wdata;
  logic        done;
  logic [31:0] done_rdata;
  logic        pending, is_write;
  logic        sel_n, rd_n, wr_n;
  logic [4:0]  reg_adr;
  logic [3:0]  be_n;
  logic        adr_strobe_n;
  logic [31:0] din, dout;
  logic        dout_oe;
  logic        ready_n;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_addr, m_data;

  always #10 clk = ~clk;

  ptap_port u0 (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .post_valid(post_valid),
    .post_write(post_write), .post_addr(post_addr), .post_wdata(post_wdata),
    .done(done), .done_rdata(done_rdata), .pending(pending), .is_write(is_write),
    .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .reg_adr(reg_adr), .be_n(be_n),
    .adr_strobe_n(adr_strobe_n), .din(din), .dout(dout), .dout_oe(dout_oe),
    .ready_n(ready_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] half_of(input logic [31:0] w, input logic [3:0] ben);
    logic lo, hi;
    lo = ~&ben[1:0];
    hi = ~&ben[3:2];
    return (hi && !lo) ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  function automatic logic [31:0] reg_word(input int a);
    if (a == 10) return m_addr;
    if (a == 8)  return m_data;
    return 32'h0;
  endfunction

  task automatic go_idle();
    sel_n = 1; rd_n = 1; wr_n = 1; adr_strobe_n = 1;
    reg_adr = 0; be_n = 4'hF; din = 0;
  endtask

  task automatic host_post(input logic w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    post_valid = 1; post_write = w; post_addr = a; post_wdata = d;
    @(negedge clk);
    post_valid = 0;
  endtask

  task automatic do_write(input logic [3:0] ben, input logic [31:0] d, input logic strobe);
    @(negedge clk);
    sel_n = 0; wr_n = 0; reg_adr = 5'd8; be_n = ben; din = d; adr_strobe_n = ~strobe;
    @(negedge clk);
    go_idle();
  endtask

  task automatic do_read(input int a, input logic [3:0] ben,
                         output logic [31:0] v, output logic oe);
    sel_n = 0; rd_n = 0; reg_adr = 5'(a); be_n = ben;
    #1; v = dout; oe = dout_oe;
    go_idle();
    #1;
  endtask

  task automatic do_strobe(input int a, input logic [3:0] ben, input logic sel,
                           output logic [31:0] v, output logic oe);
    adr_strobe_n = 0; sel_n = sel; reg_adr = 5'(a); be_n = ben;
    #1; v = dout; oe = dout_oe;
    go_idle();
    #1;
  endtask

  task automatic do_complete();
    @(negedge clk);
    ready_n = 0;
    @(negedge clk);
    ready_n = 1;
    chk("R3 pending cleared", {31'b0, pending}, 32'd0);
    chk("R3 direction cleared", {31'b0, is_write}, 32'd0);
    chk("R3 done pulse", {31'b0, done}, 32'd1);
    chk("R3 done_rdata", done_rdata, m_data);
    @(negedge clk);
    chk("R3 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic do_reset(input logic wide);
    rst = 1; wide_mode = wide;
    post_valid = 0; post_write = 0; post_addr = 0; post_wdata = 0; ready_n = 1;
    go_idle();
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", {31'b0, pending}, 32'd0);
    chk("R1 done in reset", {31'b0, done}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 pending after reset", {31'b0, pending}, 32'd0);
    chk("R1 is_write after reset", {31'b0, is_write}, 32'd0);
    chk("R1 oe after reset", {31'b0, dout_oe}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, lo_v, hi_v;
    logic        oe;

    // ---------------- 32-bit bus ----------------
    do_reset(1'b1);
    m_addr = 32'hA5C3_1E68;
    m_data = 32'h0BAD_F00D;
    host_post(1'b1, m_addr, m_data);
    chk("R2 pending set", {31'b0, pending}, 32'd1);
    chk("R2 direction write", {31'b0, is_write}, 32'd1);

    // R5: strobe ignores index, byte enables and select
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_strobe(a, 4'(b), a[0], v, oe);
        chk("R5 strobe data", v, m_addr);
        chk("R5 strobe oe", {31'b0, oe}, 32'd1);
      end
    end

    // R7: register map; R12: data holds host write data
    for (int a = 0; a < 32; a++) begin
      do_read(a, 4'h0, v, oe);
      chk("R7 read data", v, reg_word(a));
      chk("R7 read oe", {31'b0, oe}, 32'd1);
    end
    do_read(8, 4'h0, v, oe);
    chk("R12 write data loaded", v, 32'h0BAD_F00D);

    // R10: select without read, and fully idle
    sel_n = 0; #1;
    chk("R10 oe select only", {31'b0, dout_oe}, 32'd0);
    go_idle(); #1;
    chk("R10 oe idle", {31'b0, dout_oe}, 32'd0);

    // R8: byte-lane writes over every byte-enable code
    for (int b = 0; b < 16; b++) begin
      logic [31:0] d;
      d = 32'h1357_9BDF * (b + 3) + 32'h0101_0101 * b;
      do_write(4'(b), d, 1'b0);
      for (int i = 0; i < 4; i++) if (!b[i]) m_data[8*i +: 8] = d[8*i +: 8];
      do_read(8, 4'h0, v, oe);
      chk("R8 lane write", v, m_data);
    end
    chk("R3 still pending while ready held off", {31'b0, pending}, 32'd1);

    // R11: write while strobe active is dropped
    do_write(4'h0, ~m_data, 1'b1);
    do_read(8, 4'h0, v, oe);
    chk("R11 write under strobe ignored", v, m_data);

    do_complete();

    // R11: write while idle is dropped
    do_write(4'h0, 32'hFFFF_0000, 1'b0);
    do_read(8, 4'h0, v, oe);
    chk("R11 idle write ignored", v, m_data);

    // R4: ready while idle
    @(negedge clk); ready_n = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 no done while idle", {31'b0, done}, 32'd0);
      chk("R4 still idle", {31'b0, pending}, 32'd0);
    end
    ready_n = 1;

    // R12: host read clears data; R2: second post while pending ignored
    m_addr = 32'h4000_2A5C;
    host_post(1'b0, m_addr, 32'hDEAD_BEEF);
    m_data = 32'h0;
    chk("R2 direction read", {31'b0, is_write}, 32'd0);
    do_read(8, 4'h0, v, oe);
    chk("R12 read clears data", v, 32'h0);
    host_post(1'b1, 32'h1111_2222, 32'h3333_4444);
    do_strobe(0, 4'hF, 1'b1, v, oe);
    chk("R2 address kept on blocked post", v, m_addr);
    chk("R2 direction kept on blocked post", {31'b0, is_write}, 32'd0);
    do_read(8, 4'h0, v, oe);
    chk("R2 data kept on blocked post", v, m_data);
    do_write(4'h0, 32'hC0DE_CAFE, 1'b0);
    m_data = 32'hC0DE_CAFE;
    do_complete();

    // ---------------- 16-bit bus ----------------
    do_reset(1'b0);
    m_addr = 32'h9E37_79B9;
    m_data = 32'h6A09_E667;
    host_post(1'b1, m_addr, m_data);

    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_strobe(a, 4'(b), a[1], v, oe);
        chk("R6 narrow strobe", v, {16'h0, m_addr[15:0]});
      end
    end

    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_read(a, 4'(b), v, oe);
        chk("R9 narrow read", v, half_of(reg_word(a), 4'(b)));
      end
    end

    for (int b = 0; b < 16; b++) begin
      logic [31:0] d;
      d = 32'hFACE_0000 + 32'h0000_1111 * (b + 1);
      do_write(4'(b), d, 1'b0);
      if (~&b[1:0])      m_data[15:0]  = d[15:0];
      else if (~&b[3:2]) m_data[31:16] = d[15:0];
      do_read(8, 4'hC, lo_v, oe);
      do_read(8, 4'h3, hi_v, oe);
      chk("R9 narrow write", {hi_v[15:0], lo_v[15:0]}, m_data);
    end

    do_complete();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule